// File: doc/BRIEF.md
# EDH Error-Flag Port

This block is the five-pin flag port of an error detection and handling engine. It gives outside logic a small, pin-level way to see and to set the three groups of error flags that travel in each outgoing error packet: full-field, active-picture and ancillary. It also exposes a fourth, control group. A two-bit group select picks the group on the port, and a direction input sets the flag pins as outputs (read) or as inputs (write). In the design the bidirectional pins appear as separate in, out and output-enable signals.

A value written through the port is kept as a pending override for its group. That override wins over the host's flags for the next error packet only. The packet-send strobe clears every pending override, and the block pulses a one-shot strobe when a packet takes any port-written flags.

A mapping mode lets one device copy its flags into a second device. In this mode the block drives the select lines itself and steps through all four groups, one group per clock. Packet assembly and the host register interface lie outside the block. It receives the host flags and presents the merged flag vectors.

Top module: `edh_flag_port`

## Requirements
- R1: With `dir_rd` high, `flag_oe` is 1 and `flag_out` shows the merged flags of the group picked by the select. Select 0 picks full-field, 1 picks active-picture and 2 picks ancillary. Bits 4..0 of each group are UES, IDA, IDH, EDA and EDH.
- R2: Select 3 reads the control group. Bit 4 is `inout_ind`, bit 3 is the merged active-picture CRC-valid bit, bit 2 is the merged full-field CRC-valid bit, and bits 1..0 read 0.
- R3: With `dir_rd` low, `flag_oe` is 0 and `flag_in` is captured into the group on `sel_in` at the clock edge. From that edge on, the merged output for that group equals the written value.
- R4: While an override is pending for a group, changes to the host flags of that group do not reach its merged output.
- R5: A cycle with `send_stb` high clears all pending overrides, so after that edge the merged outputs equal the host flags. `ovr_stb` is high exactly in a `send_stb` cycle in which an override is pending.
- R6: A write to select 3 loads bit 3 as the active-picture CRC-valid override and bit 2 as the full-field CRC-valid override. Bit 4 (in/out) and bits 1..0 have no effect.
- R7: With `map_en` and `dir_rd` both high, `sel_oe` is 1. `sel_out` is 0 in the first mapping cycle, then advances by one each clock and wraps 3 to 0, and `flag_out` carries the group that `sel_out` names.
- R8: With `dir_rd` low, mapping is not active whatever `map_en` is: `sel_oe` is 0 and writes are captured as in R3.
- R9: After reset no override is pending, the merged outputs equal the host flags, `sel_out` is 0, `sel_oe` is 0 and `ovr_stb` stays low.
- R10: A write in the same cycle as `send_stb` survives the clear and stays pending for the following packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rd | input | 1 | 1 = flag pins are outputs (read), 0 = inputs (write) |
| map_en | input | 1 | Request for the self-stepping mapping mode |
| sel_in | input | 2 | Group select driven from outside |
| sel_out | output | 2 | Group select driven by the block in mapping mode |
| sel_oe | output | 1 | Output enable for the select pins |
| flag_in | input | 5 | Flag pins as inputs |
| flag_out | output | 5 | Flag pins as outputs |
| flag_oe | output | 1 | Output enable for the flag pins |
| send_stb | input | 1 | Outgoing error packet is being sent |
| ovr_stb | output | 1 | The packet being sent takes port-written flags |
| inout_ind | input | 1 | In/out indication reported in the control group |
| host_ff | input | 5 | Host full-field flags |
| host_ap | input | 5 | Host active-picture flags |
| host_anc | input | 5 | Host ancillary flags |
| host_apv | input | 1 | Host active-picture CRC-valid bit |
| host_ffv | input | 1 | Host full-field CRC-valid bit |
| out_ff | output | 5 | Merged full-field flags |
| out_ap | output | 5 | Merged active-picture flags |
| out_anc | output | 5 | Merged ancillary flags |
| out_apv | output | 1 | Merged active-picture CRC-valid bit |
| out_ffv | output | 1 | Merged full-field CRC-valid bit |

## Verification
The hardest case to reach from the ports is a write that lands in the same cycle as the packet-send strobe. Here the clear and the capture compete for the same pending bit, and the write must win. The stimulus table holds a vector that writes while `send_stb` is high with nothing pending. It follows with a read of that group, then a second send that must both raise `ovr_stb` and return the group to the host value. The mapping walk is entered only after `dir_rd` has been high for a cycle. It is sampled at every step to confirm that `sel_out` starts at zero, wraps, and keeps `flag_out` in step with it.

// File: rtl/edh_fp_pkg.sv
package edh_fp_pkg;

  localparam int FLAG_W = 5;
  localparam int GRP_N  = 4;
  localparam int SEL_W  = $clog2(GRP_N);

  typedef enum logic [SEL_W-1:0] {
    GRP_FF  = 2'd0,
    GRP_AP  = 2'd1,
    GRP_ANC = 2'd2,
    GRP_CTL = 2'd3
  } grp_e;

  // Control group layout: top bit in/out, then AP valid, then FF valid.
  localparam int CTL_IO_BIT  = FLAG_W - 1;
  localparam int CTL_APV_BIT = FLAG_W - 2;
  localparam int CTL_FFV_BIT = FLAG_W - 3;

  function automatic logic [FLAG_W-1:0] ctl_word(input logic io, input logic apv,
                                                 input logic ffv);
    logic [FLAG_W-1:0] w;
    w = '0;
    w[CTL_IO_BIT]  = io;
    w[CTL_APV_BIT] = apv;
    w[CTL_FFV_BIT] = ffv;
    return w;
  endfunction

  function automatic logic [FLAG_W-1:0] merge_flags(input logic pend,
                                                    input logic [FLAG_W-1:0] ovr,
                                                    input logic [FLAG_W-1:0] host);
    return pend ? ovr : host;
  endfunction

  function automatic logic [SEL_W-1:0] step_sel(input logic [SEL_W-1:0] s);
    return s + 1'b1;
  endfunction

endpackage

// File: rtl/fp_ovr_store.sv
module fp_ovr_store
  import edh_fp_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_grp,
  input  logic [W-1:0]     wr_data,
  input  logic             clr,
  output logic [GRP_N-1:0] pend,
  output logic [W-1:0]     ovr_ff,
  output logic [W-1:0]     ovr_ap,
  output logic [W-1:0]     ovr_anc,
  output logic             ovr_apv,
  output logic             ovr_ffv
);
  localparam int FLAG_GRPS = GRP_N - 1;

  logic [W-1:0] val [FLAG_GRPS];

  for (genvar g = 0; g < FLAG_GRPS; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && (wr_grp == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val[g]  <= '0;
        pend[g] <= 1'b0;
      end else if (hit) begin
        val[g]  <= wr_data;
        pend[g] <= 1'b1;
      end else if (clr) begin
        pend[g] <= 1'b0;
      end
    end
  end

  logic ctl_hit;
  assign ctl_hit = wr_en && (wr_grp == GRP_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_apv        <= 1'b0;
      ovr_ffv        <= 1'b0;
      pend[GRP_N-1]  <= 1'b0;
    end else if (ctl_hit) begin
      ovr_apv        <= wr_data[CTL_APV_BIT];
      ovr_ffv        <= wr_data[CTL_FFV_BIT];
      pend[GRP_N-1]  <= 1'b1;
    end else if (clr) begin
      pend[GRP_N-1]  <= 1'b0;
    end
  end

  assign ovr_ff  = val[GRP_FF];
  assign ovr_ap  = val[GRP_AP];
  assign ovr_anc = val[GRP_ANC];
endmodule

// File: rtl/fp_map_seq.sv
module fp_map_seq
  import edh_fp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  output logic [SEL_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (act) cnt <= step_sel(cnt);
    else          cnt <= '0;
  end
endmodule

// File: rtl/fp_grp_mux.sv
module fp_grp_mux
  import edh_fp_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     ff,
  input  logic [W-1:0]     ap,
  input  logic [W-1:0]     anc,
  input  logic [W-1:0]     ctl,
  output logic [W-1:0]     y
);
  always_comb begin
    unique case (grp_e'(sel))
      GRP_FF:  y = ff;
      GRP_AP:  y = ap;
      GRP_ANC: y = anc;
      default: y = ctl;
    endcase
  end
endmodule

// File: rtl/edh_flag_port.sv
module edh_flag_port
  import edh_fp_pkg::*;
#(
  parameter int W  = FLAG_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rd,
  input  logic          map_en,
  input  logic [SW-1:0] sel_in,
  output logic [SW-1:0] sel_out,
  output logic          sel_oe,
  input  logic [W-1:0]  flag_in,
  output logic [W-1:0]  flag_out,
  output logic          flag_oe,
  input  logic          send_stb,
  output logic          ovr_stb,
  input  logic          inout_ind,
  input  logic [W-1:0]  host_ff,
  input  logic [W-1:0]  host_ap,
  input  logic [W-1:0]  host_anc,
  input  logic          host_apv,
  input  logic          host_ffv,
  output logic [W-1:0]  out_ff,
  output logic [W-1:0]  out_ap,
  output logic [W-1:0]  out_anc,
  output logic          out_apv,
  output logic          out_ffv
);
  // Named internal events, visible to the bound checker.
  logic             map_act;
  logic             wr_ev;
  logic [GRP_N-1:0] pend;
  logic [SW-1:0]    map_cnt;
  logic [SW-1:0]    rd_sel;
  logic [W-1:0]     ovr_ff, ovr_ap, ovr_anc;
  logic             ovr_apv, ovr_ffv;
  logic [W-1:0]     ctl_rd;

  assign map_act = map_en && dir_rd;
  assign wr_ev   = !dir_rd;

  fp_ovr_store #(.W(W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ev),
    .wr_grp  (sel_in),
    .wr_data (flag_in),
    .clr     (send_stb),
    .pend    (pend),
    .ovr_ff  (ovr_ff),
    .ovr_ap  (ovr_ap),
    .ovr_anc (ovr_anc),
    .ovr_apv (ovr_apv),
    .ovr_ffv (ovr_ffv)
  );

  fp_map_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (map_act),
    .cnt   (map_cnt)
  );

  assign out_ff  = merge_flags(pend[GRP_FF],  ovr_ff,  host_ff);
  assign out_ap  = merge_flags(pend[GRP_AP],  ovr_ap,  host_ap);
  assign out_anc = merge_flags(pend[GRP_ANC], ovr_anc, host_anc);
  assign out_apv = pend[GRP_CTL] ? ovr_apv : host_apv;
  assign out_ffv = pend[GRP_CTL] ? ovr_ffv : host_ffv;
  assign ctl_rd  = ctl_word(inout_ind, out_apv, out_ffv);

  assign rd_sel  = map_act ? map_cnt : sel_in;
  assign sel_out = map_cnt;
  assign sel_oe  = map_act;
  assign flag_oe = dir_rd;
  assign ovr_stb = send_stb && (|pend);

  fp_grp_mux #(.W(W)) u_mux (
    .sel (rd_sel),
    .ff  (out_ff),
    .ap  (out_ap),
    .anc (out_anc),
    .ctl (ctl_rd),
    .y   (flag_out)
  );
endmodule

// File: rtl/edh_flag_port_chk.sv
module edh_flag_port_chk
  import edh_fp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dir_rd,
  input logic             map_en,
  input logic [SEL_W-1:0] sel_in,
  input logic [SEL_W-1:0] sel_out,
  input logic             sel_oe,
  input logic [FLAG_W-1:0] flag_in,
  input logic             send_stb,
  input logic             ovr_stb,
  input logic [FLAG_W-1:0] host_ff,
  input logic [FLAG_W-1:0] out_ff,
  input logic             host_apv,
  input logic             out_apv,
  input logic [GRP_N-1:0] pend
);
  logic mact;
  assign mact = map_en && dir_rd;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && sel_in == GRP_FF) |=> (out_ff == $past(flag_in)));   // R3
  AST_SEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (send_stb && dir_rd) |=> (out_ff == host_ff && out_apv == host_apv)); // R5
  AST_STB_NEEDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_stb |-> send_stb);                                            // R5
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && !send_stb) |=> $stable(pend));                         // R4
  AST_MAP_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mact) |-> (sel_out == '0));                                 // R7
  AST_MAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mact && $past(mact)) |-> (sel_out == SEL_W'($past(sel_out) + 1'b1))); // R7
  AST_NO_MAP_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_rd |-> !sel_oe);                                             // R8
  AST_SEND_WRITE_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (send_stb && !dir_rd && sel_in == GRP_FF) |=> pend[GRP_FF]);      // R10
endmodule

bind edh_flag_port edh_flag_port_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .dir_rd   (dir_rd),
  .map_en   (map_en),
  .sel_in   (sel_in),
  .sel_out  (sel_out),
  .sel_oe   (sel_oe),
  .flag_in  (flag_in),
  .send_stb (send_stb),
  .ovr_stb  (ovr_stb),
  .host_ff  (host_ff),
  .out_ff   (out_ff),
  .host_apv (host_apv),
  .out_apv  (out_apv),
  .pend     (pend)
);

// File: tb/edh_flag_port_tb_top.sv
module edh_flag_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir_rd, map_en, send_stb, inout_ind, host_apv, host_ffv;
  logic [1:0] sel_in;
  logic [4:0] flag_in, host_ff, host_ap, host_anc;
  logic [1:0] sel_out;
  logic       sel_oe, flag_oe, ovr_stb, out_apv, out_ffv;
  logic [4:0] flag_out, out_ff, out_ap, out_anc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  edh_flag_port dut_i (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .map_en(map_en),
    .sel_in(sel_in), .sel_out(sel_out), .sel_oe(sel_oe),
    .flag_in(flag_in), .flag_out(flag_out), .flag_oe(flag_oe),
    .send_stb(send_stb), .ovr_stb(ovr_stb), .inout_ind(inout_ind),
    .host_ff(host_ff), .host_ap(host_ap), .host_anc(host_anc),
    .host_apv(host_apv), .host_ffv(host_ffv),
    .out_ff(out_ff), .out_ap(out_ap), .out_anc(out_anc),
    .out_apv(out_apv), .out_ffv(out_ffv)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {dir, sel, flag_in, send, exp flag_out, exp ovr_stb}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 2'd0, 5'h00, 1'b0, 5'h15, 1'b0},  // R1 FF
    {1'b1, 2'd1, 5'h00, 1'b0, 5'h0A, 1'b0},  // R1 AP
    {1'b1, 2'd2, 5'h00, 1'b0, 5'h13, 1'b0},  // R1 ANC
    {1'b1, 2'd3, 5'h00, 1'b0, 5'h18, 1'b0},  // R2 control
    {1'b0, 2'd1, 5'h1F, 1'b0, 5'h00, 1'b0},  // R3 write AP
    {1'b1, 2'd1, 5'h00, 1'b0, 5'h1F, 1'b0},  // R3 read back
    {1'b1, 2'd0, 5'h00, 1'b0, 5'h15, 1'b0},  // R3 other group untouched
    {1'b0, 2'd3, 5'h07, 1'b0, 5'h00, 1'b0},  // R6 io=0 ignored, apv=0 ffv=1
    {1'b1, 2'd3, 5'h00, 1'b0, 5'h14, 1'b0},  // R6
    {1'b1, 2'd2, 5'h00, 1'b1, 5'h13, 1'b1},  // R5 send with pending
    {1'b1, 2'd1, 5'h00, 1'b0, 5'h0A, 1'b0},  // R5 cleared
    {1'b1, 2'd3, 5'h00, 1'b0, 5'h18, 1'b0},  // R5 cleared
    {1'b0, 2'd0, 5'h00, 1'b1, 5'h00, 1'b0},  // R10 write during send
    {1'b1, 2'd0, 5'h00, 1'b0, 5'h00, 1'b0},  // R10 survived
    {1'b1, 2'd0, 5'h00, 1'b1, 5'h00, 1'b1},  // R10/R5 consumed
    {1'b1, 2'd0, 5'h00, 1'b0, 5'h15, 1'b0}   // R5 back to host
  };

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dir_rd = 1; map_en = 0; send_stb = 0; sel_in = 0; flag_in = 0;
    inout_ind = 1; host_ff = 5'h15; host_ap = 5'h0A; host_anc = 5'h13;
    host_apv = 1; host_ffv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    send_stb = 1; #1;
    // R9 reset state
    chk("R9 ovr_stb", ovr_stb, 0);
    chk("R9 out_ff", out_ff, 5'h15);
    chk("R9 sel_oe", sel_oe, 0);
    chk("R9 sel_out", sel_out, 0);
    chk("R9 out_apv", out_apv, 1);
    @(negedge clk); send_stb = 0;

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      dir_rd = v[14]; sel_in = v[13:12]; flag_in = v[11:7]; send_stb = v[6];
      #1;
      chk("R1 flag_oe", flag_oe, v[14]);
      chk("R5 ovr_stb", ovr_stb, v[0]);
      if (v[14]) chk("R1/R2 flag_out", flag_out, v[5:1]);
      @(negedge clk);
    end
    dir_rd = 1; send_stb = 0;

    // R6: merged valid bits after control write were checked via read; check ports
    @(negedge clk); dir_rd = 0; sel_in = 3; flag_in = 5'h08;
    @(negedge clk); dir_rd = 1; #1;
    chk("R6 out_apv", out_apv, 1);
    chk("R6 out_ffv", out_ffv, 0);
    send_stb = 1; @(negedge clk); send_stb = 0;

    // R4: override holds against host change
    dir_rd = 0; sel_in = 2; flag_in = 5'h05;
    @(negedge clk); dir_rd = 1; host_anc = 5'h1E; #1;
    chk("R4 out_anc", out_anc, 5'h05);
    host_ap = 5'h11; #1;
    chk("R4 host passes when not pending", out_ap, 5'h11);
    send_stb = 1; @(negedge clk); send_stb = 0; #1;
    chk("R5 out_anc host", out_anc, 5'h1E);

    // R8: map_en with dir low
    @(negedge clk); map_en = 1; dir_rd = 0; sel_in = 0; flag_in = 5'h09; #1;
    chk("R8 sel_oe", sel_oe, 0);
    chk("R8 flag_oe", flag_oe, 0);
    @(negedge clk); #1;
    chk("R8 write captured", out_ff, 5'h09);
    map_en = 0; dir_rd = 1;

    // R7: mapping walk, dir high one cycle ahead
    @(negedge clk); map_en = 1; #1;
    chk("R7 sel_oe", sel_oe, 1);
    for (int k = 0; k < 6; k++) begin
      int e;
      e = k % 4;
      chk("R7 sel_out", sel_out, e);
      case (e)
        0: chk("R7 flag_out", flag_out, 5'h09);
        1: chk("R7 flag_out", flag_out, 5'h11);
        2: chk("R7 flag_out", flag_out, 5'h1E);
        default: chk("R7 flag_out", flag_out, 5'h18);
      endcase
      @(negedge clk); #1;
    end
    map_en = 0; #1;
    chk("R7 sel_oe off", sel_oe, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule